// File: doc/BRIEF.md
# Phase-locked 2:1 clock-ratio sample bridge

This block carries a stream of samples from a slow clock domain into a fast domain that runs at exactly twice the slow rate, and carries results back. Both clocks come from one PLL, and each slow rising edge coincides with a fast rising edge. Because the clocks are related, no asynchronous FIFO is used. A flop in the slow domain inverts on every slow edge. The fast domain registers that flop, compares it with its own previous value, and registers the comparison. The result is a phase flag, high in the fast cycle that begins on a slow edge. The slow clock never enters any logic equation.

On the forward side, each sample is captured into a holding register on the slow edge where `s_valid` is high. In the following fast phase cycle, the fast side presents that sample with a one-cycle strobe. A downstream filter running on the fast clock therefore sees a new sample on alternate cycles, and the sample rate stays at the slow-clock rate. On the return side, a result flagged on the fast clock is latched and handed back as a one-slow-cycle pulse.

Neither stream has a ready signal. The rate is fixed by the clocks, so every beat must be accepted: the downstream logic takes each `f_valid` beat, and the slow-domain consumer takes each `o_valid` beat. A return source may raise `r_valid` at most once within any slow cycle, which means at most once across the two fast edges in that cycle.

Top module: `clk2x_bridge`

## Requirements
- R1: While `rst_n` is low, `f_phase`, `f_valid` and `o_valid` are 0, and `f_data` and `o_data` are 0. After release, `f_phase` first goes high in the fast cycle that starts at the second slow rising edge after release, which is the first edge after the toggle has changed once.
- R2: From then on, `f_phase` is high for exactly the one fast cycle that begins at each slow rising edge, and low for the other fast cycle.
- R3: `f_valid` is high only in a cycle where `f_phase` is high. It is high there exactly when `s_valid` was high at the preceding slow rising edge.
- R4: In a cycle where `f_valid` is high, `f_data` equals the `s_data` value captured at the preceding slow rising edge. `f_data` changes only at the start of a cycle where `f_phase` is high.
- R5: A slow cycle with `s_valid` low produces no strobe, and `f_data` keeps the last valid sample. Values on `s_data` that are not qualified by `s_valid` never appear on `f_data`.
- R6: `r_valid` may be sampled at either fast edge inside slow cycle k. In both cases, `o_valid` is then high for the whole of slow cycle k+1, and `o_data` equals the `r_data` taken with it.
- R7: Without a new `r_valid`, `o_valid` stays low and `o_data` holds its value. Results come out in the order they went in, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock, edges aligned to `clk_fast` |
| clk_fast | input | 1 | Fast clock, twice the slow rate |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| s_valid | input | 1 | Slow-domain sample qualifier |
| s_data | input | W | Slow-domain sample |
| f_phase | output | 1 | Fast-domain phase flag, high in the cycle starting at a slow edge |
| f_valid | output | 1 | Fast-domain sample strobe |
| f_data | output | W | Fast-domain sample |
| r_valid | input | 1 | Fast-domain result qualifier |
| r_data | input | W | Fast-domain result |
| o_valid | output | 1 | Slow-domain result pulse, one slow cycle long |
| o_data | output | W | Slow-domain result |

## Verification
The checker watches the following on every edge:
- the phase flag is one fast cycle wide and is never high as a slow edge arrives;
- the strobe stays inside the phase cycle;
- `f_data` moves only at the start of a phase cycle;
- `o_data` changes only when it comes with a pulse;
- all outputs are quiet during reset.

The following need the bench's scenarios, which predict exact values per slow cycle:
- which sample arrives in which fast cycle, and that gaps in `s_valid` are honoured;
- that the first phase cycle comes only after the toggle has changed once;
- the one-slow-cycle latency of the return path for results taken on either fast edge, and that round-trip order is preserved.

// File: rtl/br_pkg.sv
package br_pkg;
  parameter int unsigned BR_SAMPLE_W = 16;
endpackage

// File: rtl/br_slow_capture.sv
module br_slow_capture #(
  parameter int unsigned W = br_pkg::BR_SAMPLE_W
) (
  input  logic         clk_slow,
  input  logic         rst_n,
  input  logic         s_valid,
  input  logic [W-1:0] s_data,
  output logic         tog_o,
  output logic [W-1:0] hold_o,
  output logic         fresh_o
);
  // Free-running divider: flips on every slow edge.
  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) tog_o <= 1'b0;
    else        tog_o <= ~tog_o;
  end

  // Held copy of the sample, stable across the whole slow cycle.
  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      hold_o  <= '0;
      fresh_o <= 1'b0;
    end else begin
      fresh_o <= s_valid;
      if (s_valid) hold_o <= s_data;
    end
  end
endmodule

// File: rtl/br_phase_detect.sv
module br_phase_detect (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic tog_i,
  output logic edge_o,
  output logic phase_o
);
  logic tog_f, tog_f_d;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      tog_f   <= 1'b0;
      tog_f_d <= 1'b0;
      phase_o <= 1'b0;
    end else begin
      tog_f   <= tog_i;
      tog_f_d <= tog_f;
      phase_o <= edge_o;
    end
  end

  // High in the fast cycle just before a slow edge.
  assign edge_o = tog_f ^ tog_f_d;
endmodule

// File: rtl/br_fast_out.sv
module br_fast_out #(
  parameter int unsigned W = br_pkg::BR_SAMPLE_W
) (
  input  logic         clk_fast,
  input  logic         rst_n,
  input  logic         edge_i,
  input  logic         fresh_i,
  input  logic [W-1:0] hold_i,
  output logic         f_valid,
  output logic [W-1:0] f_data
);
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      f_valid <= 1'b0;
      f_data  <= '0;
    end else begin
      f_valid <= edge_i & fresh_i;
      if (edge_i) f_data <= hold_i;
    end
  end
endmodule

// File: rtl/br_return.sv
module br_return #(
  parameter int unsigned W = br_pkg::BR_SAMPLE_W
) (
  input  logic         clk_fast,
  input  logic         clk_slow,
  input  logic         rst_n,
  input  logic         r_valid,
  input  logic [W-1:0] r_data,
  output logic         o_valid,
  output logic [W-1:0] o_data
);
  logic         ret_tog;
  logic [W-1:0] ret_hold;
  logic         ret_seen;

  // Fast side: latch result, flip a marker.
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      ret_tog  <= 1'b0;
      ret_hold <= '0;
    end else if (r_valid) begin
      ret_tog  <= ~ret_tog;
      ret_hold <= r_data;
    end
  end

  // Slow side: a marker change means a new result.
  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      ret_seen <= 1'b0;
      o_valid  <= 1'b0;
      o_data   <= '0;
    end else begin
      ret_seen <= ret_tog;
      o_valid  <= ret_tog ^ ret_seen;
      if (ret_tog ^ ret_seen) o_data <= ret_hold;
    end
  end
endmodule

// File: rtl/clk2x_bridge.sv
module clk2x_bridge #(
  parameter int unsigned W = br_pkg::BR_SAMPLE_W
) (
  input  logic         clk_slow,
  input  logic         clk_fast,
  input  logic         rst_n,
  input  logic         s_valid,
  input  logic [W-1:0] s_data,
  output logic         f_phase,
  output logic         f_valid,
  output logic [W-1:0] f_data,
  input  logic         r_valid,
  input  logic [W-1:0] r_data,
  output logic         o_valid,
  output logic [W-1:0] o_data
);
  logic         tog;
  logic         fresh;
  logic [W-1:0] hold;
  logic         edge_pre;

  br_slow_capture #(.W(W)) cap_i (
    .clk_slow(clk_slow), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .tog_o(tog), .hold_o(hold), .fresh_o(fresh)
  );

  br_phase_detect det_i (
    .clk_fast(clk_fast), .rst_n(rst_n), .tog_i(tog),
    .edge_o(edge_pre), .phase_o(f_phase)
  );

  br_fast_out #(.W(W)) out_i (
    .clk_fast(clk_fast), .rst_n(rst_n), .edge_i(edge_pre), .fresh_i(fresh),
    .hold_i(hold), .f_valid(f_valid), .f_data(f_data)
  );

  br_return #(.W(W)) ret_i (
    .clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n),
    .r_valid(r_valid), .r_data(r_data), .o_valid(o_valid), .o_data(o_data)
  );
endmodule

// File: rtl/clk2x_bridge_chk.sv
module clk2x_bridge_chk #(
  parameter int unsigned W = br_pkg::BR_SAMPLE_W
) (
  input logic         clk_slow,
  input logic         clk_fast,
  input logic         rst_n,
  input logic         f_phase,
  input logic         f_valid,
  input logic [W-1:0] f_data,
  input logic         o_valid,
  input logic [W-1:0] o_data
);
  always @(posedge clk_fast) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!f_phase && !f_valid && !o_valid);
    end
  end

  a_r2_phase_one_cycle: assert property (@(posedge clk_fast) disable iff (!rst_n)
    f_phase |=> !f_phase);

  a_r2_phase_starts_at_slow_edge: assert property (@(posedge clk_slow) disable iff (!rst_n)
    !f_phase);

  a_r3_strobe_in_phase: assert property (@(posedge clk_fast) disable iff (!rst_n)
    f_valid |-> f_phase);

  a_r4_data_moves_on_phase: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !f_phase |-> $stable(f_data));

  a_r7_result_held: assert property (@(posedge clk_slow) disable iff (!rst_n)
    !o_valid |-> $stable(o_data));
endmodule

bind clk2x_bridge clk2x_bridge_chk #(.W(W)) chk_i (
  .clk_slow(clk_slow), .clk_fast(clk_fast), .rst_n(rst_n),
  .f_phase(f_phase), .f_valid(f_valid), .f_data(f_data),
  .o_valid(o_valid), .o_data(o_data)
);

// File: tb/clk2x_bridge_tb_top.sv
module clk2x_bridge_tb_top;
  localparam int unsigned W = 16;

  logic         clk_slow, clk_fast, rst_n;
  logic         s_valid, r_valid;
  logic [W-1:0] s_data, r_data;
  logic         f_phase, f_valid, o_valid;
  logic [W-1:0] f_data, o_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  clk2x_bridge #(.W(W)) dut_i (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst_n(rst_n),
    .s_valid(s_valid), .s_data(s_data),
    .f_phase(f_phase), .f_valid(f_valid), .f_data(f_data),
    .r_valid(r_valid), .r_data(r_data),
    .o_valid(o_valid), .o_data(o_data)
  );

  // 50 MHz slow clock, 100 MHz fast clock, rising edges set together.
  initial begin
    clk_slow = 0; clk_fast = 0;
    forever begin
      #5 clk_fast = 1; clk_slow = 1;
      #5 clk_fast = 0;
      #5 clk_fast = 1; clk_slow = 0;
      #5 clk_fast = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Model state
  logic         prev_sv, cur_sv, pend_o, a_rv;
  logic [W-1:0] prev_sd, cur_sd, last_fd, pend_od, last_od, a_rd;

  task automatic do_reset();
    rst_n = 0;
    s_valid = 0; s_data = '0; r_valid = 0; r_data = '0;
    repeat (3) @(negedge clk_fast);
    chk("R1 reset f_phase", f_phase, 0);
    chk("R1 reset f_valid", f_valid, 0);
    chk("R1 reset o_valid", o_valid, 0);
    chk("R1 reset f_data", f_data, 0);
    chk("R1 reset o_data", o_data, 0);
    while (clk_slow !== 1'b0) @(negedge clk_fast);
    rst_n = 1;
    prev_sv = 0; prev_sd = '0; last_fd = '0;
    pend_o = 0; pend_od = '0; last_od = '0;
  endtask

  // mode 1: every slot valid, loop back at midpoint edge
  // mode 2: gaps every third slot, independent returns at slow edge
  task automatic run(input int mode, input int n);
    for (int j = 0; j < n; j++) begin
      // A: next fast edge is a slow edge
      if (j > 0) begin
        chk("R2 phase low before slow edge", f_phase, 0);
        chk("R3 no strobe off phase", f_valid, 0);
        chk("R4 f_data steady off phase", f_data, last_fd);
      end
      if (mode == 1) begin
        cur_sv = 1;
        cur_sd = (j == 3) ? 16'hFFFF : (j == 4) ? 16'h0000 : W'(j * 16'h1357 + 16'h00A1);
      end else begin
        cur_sv = (j % 3) != 2;
        cur_sd = W'(j * 16'h0B0D + 16'h4242);
      end
      s_valid = cur_sv; s_data = cur_sd;
      a_rv = (mode == 2) && (j % 2 == 0);
      a_rd = W'(j * 16'h0301 + 16'h0007);
      r_valid = a_rv; r_data = a_rd;
      @(negedge clk_fast);
      // B: inside the fast cycle that began at the slow edge
      if (j == 0) chk("R1 no phase before toggle changed", f_phase, 0);
      else        chk("R2 phase high after slow edge", f_phase, 1);
      chk("R3 strobe follows s_valid", f_valid, (j > 0) && prev_sv);
      if (j > 0 && prev_sv) last_fd = prev_sd;
      if (j > 0 && !prev_sv) chk("R5 gap keeps data", f_data, last_fd);
      else                   chk("R4 f_data is captured sample", f_data, last_fd);
      chk("R6 o_valid latency", o_valid, pend_o);
      if (pend_o) last_od = pend_od;
      if (pend_o) chk("R6 o_data value", o_data, last_od);
      else        chk("R7 o_data held", o_data, last_od);
      // next window expectation
      pend_o = a_rv; pend_od = a_rd;
      r_valid = 0;
      if (mode == 1 && (j > 0) && prev_sv) begin
        r_valid = 1; r_data = last_fd ^ 16'hA5A5;
        pend_o = 1; pend_od = last_fd ^ 16'hA5A5;
      end
      // unqualified garbage on the slow input
      s_valid = 0; s_data = W'(16'hDEAD ^ j);
      prev_sv = cur_sv; prev_sd = cur_sd;
      @(negedge clk_fast);
      r_valid = 0;
    end
  endtask

  initial begin
    rst_n = 1; s_valid = 0; s_data = '0; r_valid = 0; r_data = '0;
    #1;
    do_reset();
    run(1, 40);
    do_reset();
    run(2, 40);
    finish_run();
  end

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    finish_run();
  end
endmodule